// File: doc/BRIEF.md
# Transmit Message Queue Sequencer

This block keeps up to seven outgoing bus messages in an eight-slot ring and hands them, oldest first, to a separate transmitter engine. A producer pushes a message (1 to 16 bytes plus its byte count) through the enqueue port. The sequencer watches the engine's two-bit status. It issues a start strobe with the slot's bytes and the length minus one. It issues a clear strobe when the engine reports completion or failure.

A failed message is sent again a bounded number of times. After that it is discarded so the queue keeps moving. Three conditions count as unrecoverable, and each raises a one-cycle reset request that also empties the ring:

- a push into a full ring;
- a transmit failure seen together with a receive failure;
- an engine that stays busy for too long.

Top module: `tmq_sequencer`

## Requirements
- R1: Out of reset the ring is empty. `enq_full`, `tx_start`, `tx_clear` and `reset_req` are all low, and an idle engine is not started.
- R2: The status code on `tx_status` is 0 idle, 1 busy, 2 done, 3 error. While the engine is idle and a slot is pending, `tx_start` is high in that same cycle. `tx_data` then carries the oldest slot with byte i on bits 8i+7..8i, and `tx_len_m1` carries its byte count minus one.
- R3: `enq_full` is high exactly when (write index + 1) mod 8 equals the send index, so the ring holds at most seven messages.
- R4: A push while `enq_full` is high stores nothing. `reset_req` is high in the following cycle.
- R5: A push whose length is 0 or greater than 16 is ignored, and nothing becomes pending.
- R6: On status done the sequencer raises `tx_clear` and moves the send index on by one. If another slot is waiting, it also raises `tx_start` for that slot in the same cycle, so messages leave in push order.
- R7: On status error (with `rx_error` low) the sequencer raises `tx_clear` and keeps the slot. The slot restarts on the next idle status. This repeats while the slot's retry count is below 5. On the sixth failure the slot is dropped and the next slot becomes current.
- R8: Status error with `rx_error` high raises `reset_req` in the next cycle, with no clear strobe and no retry.
- R9: A run of 2000 consecutive busy observations raises `reset_req` on the 2000th. Any observed non-busy status restarts the count.
- R10: In the cycle `reset_req` is high, both ring indices and every retry count are zero, so nothing is pending.
- R11: A start is only issued while the status is idle or done. In the cycle after any start or clear strobe the status is disregarded, and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_push | input | 1 | Push request for one message |
| enq_len | input | 5 | Byte count of the pushed message |
| enq_data | input | 128 | Message bytes, byte i at bits 8i+7..8i |
| enq_full | output | 1 | Ring full; a push now is rejected |
| tx_data | output | 128 | Bytes of the slot being started |
| tx_len_m1 | output | 4 | Byte count minus one of the slot being started |
| tx_start | output | 1 | Start strobe to the transmitter engine |
| tx_clear | output | 1 | Clears the engine's done or error status |
| tx_status | input | 2 | Engine status: 0 idle, 1 busy, 2 done, 3 error |
| rx_error | input | 1 | Receive path reports an error |
| reset_req | output | 1 | One-cycle request for a bus interface reset |

## Verification
The bench targets the retry boundary. It expects exactly five restarts and silence after the sixth failure: a limit that is off by one either resends once too often or gives up early. It checks that a done status launches the next slot in the same cycle with the right bytes, because a wrong send index would replay or skip a message. It fills the ring to seven entries, where a wrong full test either overwrites the oldest slot or never raises the reset request. It also runs the busy watchdog to the exact cycle, with and without an idle gap, to catch a counter that trips one cycle off or misses its clear.

// File: rtl/tmq_pkg.sv
`timescale 1ns/1ps
package tmq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2,
      ST_ERR  = 2'd3
   } tx_stat_e;
endpackage

// File: rtl/tmq_slot_store.sv
`timescale 1ns/1ps
module tmq_slot_store #(
   parameter int SLOTS       = 8,
   parameter int MAX_BYTES   = 16,
   parameter int RETRY_LIMIT = 5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flush,
   input  logic                               wr_en,
   input  logic [$clog2(SLOTS)-1:0]           wr_idx,
   input  logic [MAX_BYTES*8-1:0]             wr_data,
   input  logic [$clog2(MAX_BYTES)-1:0]       wr_lm1,
   input  logic [$clog2(SLOTS)-1:0]           rd_idx,
   output logic [MAX_BYTES*8-1:0]             rd_data,
   output logic [$clog2(MAX_BYTES)-1:0]       rd_lm1,
   input  logic [$clog2(SLOTS)-1:0]           rt_idx,
   input  logic                               rt_inc,
   input  logic                               rt_clr,
   output logic [$clog2(RETRY_LIMIT+1)-1:0]   rt_val
);
   localparam int IW = $clog2(SLOTS);
   localparam int DW = MAX_BYTES * 8;
   localparam int MW = $clog2(MAX_BYTES);
   localparam int RW = $clog2(RETRY_LIMIT + 1);

   logic [DW-1:0] data_arr [SLOTS];
   logic [MW-1:0] lm1_arr  [SLOTS];
   logic [RW-1:0] rt_arr   [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [DW-1:0] d_q;
      logic [MW-1:0] l_q;
      logic [RW-1:0] r_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            l_q <= '0;
            r_q <= '0;
         end else begin
            if (wr_en && wr_idx == IW'(s)) begin
               d_q <= wr_data;
               l_q <= wr_lm1;
            end
            if (flush || (rt_clr && rt_idx == IW'(s)))
               r_q <= '0;
            else if (rt_inc && rt_idx == IW'(s))
               r_q <= r_q + 1'b1;
         end
      end

      assign data_arr[s] = d_q;
      assign lm1_arr[s]  = l_q;
      assign rt_arr[s]   = r_q;

      // R7
      retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         r_q <= RW'(RETRY_LIMIT));
   end

   assign rd_data = data_arr[rd_idx];
   assign rd_lm1  = lm1_arr[rd_idx];
   assign rt_val  = rt_arr[rt_idx];
endmodule

// File: rtl/tmq_busy_watch.sv
`timescale 1ns/1ps
module tmq_busy_watch #(
   parameter int LIMIT = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic trip
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("busy limit must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign trip = tick && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || trip)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   // R9
   busy_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(LIMIT));
endmodule

// File: rtl/tmq_sequencer.sv
`timescale 1ns/1ps
module tmq_sequencer
   import tmq_pkg::*;
#(
   parameter int SLOTS       = 8,
   parameter int MAX_BYTES   = 16,
   parameter int RETRY_LIMIT = 5,
   parameter int BUSY_LIMIT  = 2000
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             enq_push,
   input  logic [$clog2(MAX_BYTES+1)-1:0]   enq_len,
   input  logic [MAX_BYTES*8-1:0]           enq_data,
   output logic                             enq_full,
   output logic [MAX_BYTES*8-1:0]           tx_data,
   output logic [$clog2(MAX_BYTES)-1:0]     tx_len_m1,
   output logic                             tx_start,
   output logic                             tx_clear,
   input  logic [1:0]                       tx_status,
   input  logic                             rx_error,
   output logic                             reset_req
);
   localparam int IW = $clog2(SLOTS);
   localparam int LW = $clog2(MAX_BYTES + 1);
   localparam int MW = $clog2(MAX_BYTES);
   localparam int RW = $clog2(RETRY_LIMIT + 1);

   if ((SLOTS < 2) || ((SLOTS & (SLOTS - 1)) != 0)) begin : g_bad_slots
      $error("slot count must be a power of two");
   end
   if ((MAX_BYTES < 2) || ((MAX_BYTES & (MAX_BYTES - 1)) != 0)) begin : g_bad_bytes
      $error("slot byte capacity must be a power of two");
   end

   logic [IW-1:0] wr_q, sd_q, sd_inc, rd_idx;
   logic          settle_q, pending, len_ok, look;
   logic          is_idle, is_busy, is_done, is_err;
   logic          trip, fault, push_take, adv, rt_inc;
   logic [RW-1:0] rt_val;
   tx_stat_e      st;

   assign st       = tx_stat_e'(tx_status);
   assign sd_inc   = sd_q + 1'b1;
   assign enq_full = (IW'(wr_q + 1'b1) == sd_q);
   assign pending  = (wr_q != sd_q);
   assign len_ok   = (enq_len != '0) && (enq_len <= LW'(MAX_BYTES));
   assign look     = !settle_q;
   assign is_idle  = look && (st == ST_IDLE);
   assign is_busy  = look && (st == ST_BUSY);
   assign is_done  = look && (st == ST_DONE);
   assign is_err   = look && (st == ST_ERR);

   assign fault     = (enq_push && enq_full) || (is_err && rx_error) || trip;
   assign push_take = enq_push && len_ok && !enq_full && !fault;

   always_comb begin
      tx_start = 1'b0;
      tx_clear = 1'b0;
      adv      = 1'b0;
      rt_inc   = 1'b0;
      rd_idx   = sd_q;
      if (!fault) begin
         if (is_done) begin
            tx_clear = 1'b1;
            adv      = 1'b1;
            if (sd_inc != wr_q) begin
               tx_start = 1'b1;
               rd_idx   = sd_inc;
            end
         end else if (is_err) begin
            tx_clear = 1'b1;
            if (rt_val < RW'(RETRY_LIMIT)) rt_inc = 1'b1;
            else                            adv    = 1'b1;
         end else if (is_idle && pending) begin
            tx_start = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q      <= '0;
         sd_q      <= '0;
         settle_q  <= 1'b0;
         reset_req <= 1'b0;
      end else if (fault) begin
         wr_q      <= '0;
         sd_q      <= '0;
         settle_q  <= 1'b0;
         reset_req <= 1'b1;
      end else begin
         reset_req <= 1'b0;
         settle_q  <= tx_start || tx_clear;
         if (push_take) wr_q <= wr_q + 1'b1;
         if (adv)       sd_q <= sd_inc;
      end
   end

   tmq_slot_store #(
      .SLOTS(SLOTS), .MAX_BYTES(MAX_BYTES), .RETRY_LIMIT(RETRY_LIMIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .flush(fault),
      .wr_en(push_take), .wr_idx(wr_q), .wr_data(enq_data),
      .wr_lm1(enq_len[MW-1:0] - 1'b1),
      .rd_idx(rd_idx), .rd_data(tx_data), .rd_lm1(tx_len_m1),
      .rt_idx(sd_q), .rt_inc(rt_inc), .rt_clr(adv), .rt_val(rt_val)
   );

   tmq_busy_watch #(.LIMIT(BUSY_LIMIT)) u_watch (
      .clk(clk), .rst_n(rst_n),
      .tick(is_busy), .clr((look && !is_busy) || fault), .trip(trip)
   );

   // R4
   full_push_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_push && enq_full) |=> reset_req);
   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (wr_q == '0) && (sd_q == '0));
   // R11
   start_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> (tx_status == ST_IDLE) || (tx_status == ST_DONE));
   // R11
   settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start || tx_clear) |=> !tx_start && !tx_clear);
   // R5
   bad_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_push && !len_ok && !fault) |=> $stable(wr_q));
   // R6
   done_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_done && !fault) |=> sd_q == IW'($past(sd_q) + 1'b1));
endmodule

// File: tb/tb_tmq_sequencer.sv
`timescale 1ns/1ps
module tb_tmq_sequencer;
   import tmq_pkg::*;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enq_push = 1'b0;
   logic [4:0]   enq_len = '0;
   logic [127:0] enq_data = '0;
   logic         enq_full;
   logic [127:0] tx_data;
   logic [3:0]   tx_len_m1;
   logic         tx_start, tx_clear;
   logic [1:0]   tx_status = ST_IDLE;
   logic         rx_error = 1'b0;
   logic         reset_req;

   int total = 0;
   int bad   = 0;

   localparam int       TBL_N = 4;
   localparam int       TBL_LEN [TBL_N] = '{2, 5, 16, 1};
   localparam bit [7:0] TBL_B0  [TBL_N] = '{8'h40, 8'h10, 8'hA0, 8'h3C};

   always #5 clk = ~clk;

   tmq_sequencer dut (
      .clk(clk), .rst_n(rst_n), .enq_push(enq_push), .enq_len(enq_len),
      .enq_data(enq_data), .enq_full(enq_full), .tx_data(tx_data),
      .tx_len_m1(tx_len_m1), .tx_start(tx_start), .tx_clear(tx_clear),
      .tx_status(tx_status), .rx_error(rx_error), .reset_req(reset_req)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(input logic [7:0] b0, input int len);
      logic [127:0] v = '0;
      for (int i = 0; i < len; i++) v[8*i +: 8] = b0 + 8'(i);
      return v;
   endfunction

   task automatic do_push(input int len, input logic [7:0] b0);
      @(negedge clk);
      enq_push = 1'b1;
      enq_len  = 5'(len);
      enq_data = mk(b0, len);
      @(negedge clk);
      enq_push = 1'b0;
      #1;
   endtask

   task automatic expect_start(input string tag, input logic [7:0] b0, input int len);
      check({tag, " start"}, tx_start, 1);
      check({tag, " byte0"}, tx_data[7:0], b0);
      check({tag, " last byte"}, tx_data[8*(len-1) +: 8], 8'(b0 + 8'(len - 1)));
      check({tag, " len_m1"}, tx_len_m1, len - 1);
   endtask

   initial begin
      #1_500_000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      check("R1 full", enq_full, 0);
      check("R1 start", tx_start, 0);
      check("R1 clear", tx_clear, 0);
      check("R1 reset_req", reset_req, 0);

      // R2 table walk: push, start, complete
      for (int k = 0; k < TBL_N; k++) begin
         do_push(TBL_LEN[k], TBL_B0[k]);
         expect_start("R2 table", TBL_B0[k], TBL_LEN[k]);
         @(negedge clk); tx_status = ST_BUSY;
         @(negedge clk); @(negedge clk);
         tx_status = ST_DONE; #1;
         check("R6 table clear", tx_clear, 1);
         check("R6 table no next", tx_start, 0);
         @(negedge clk); tx_status = ST_IDLE; #1;
         check("R11 settle quiet", tx_start, 0);
      end

      // R6 ordering: done launches next slot directly
      do_push(2, 8'h11);
      expect_start("R6 A", 8'h11, 2);
      @(negedge clk); tx_status = ST_BUSY;
      do_push(3, 8'h21);
      do_push(4, 8'h31);
      tx_status = ST_DONE; #1;
      check("R6 clear A", tx_clear, 1);
      expect_start("R6 B", 8'h21, 3);
      @(negedge clk); tx_status = ST_BUSY;
      @(negedge clk); tx_status = ST_DONE; #1;
      expect_start("R6 C", 8'h31, 4);
      @(negedge clk); tx_status = ST_BUSY;
      @(negedge clk); tx_status = ST_DONE; #1;
      check("R6 last clear", tx_clear, 1);
      check("R6 last no start", tx_start, 0);
      @(negedge clk); tx_status = ST_IDLE;

      // R7 retry five times, drop on sixth failure
      do_push(3, 8'h50);
      expect_start("R7 first", 8'h50, 3);
      for (int e = 1; e <= 6; e++) begin
         @(negedge clk); tx_status = ST_BUSY;
         @(negedge clk); tx_status = ST_ERR; #1;
         check("R7 error clear", tx_clear, 1);
         check("R7 error no start", tx_start, 0);
         @(negedge clk); tx_status = ST_IDLE; #1;
         check("R11 settle after error", tx_start, 0);
         @(negedge clk); #1;
         if (e <= 5) begin
            check("R7 restart", tx_start, 1);
            check("R7 restart byte0", tx_data[7:0], 8'h50);
         end else begin
            check("R7 dropped", tx_start, 0);
         end
      end
      do_push(1, 8'h77);
      expect_start("R7 next after drop", 8'h77, 1);
      @(negedge clk); tx_status = ST_BUSY;
      @(negedge clk); tx_status = ST_DONE;
      @(negedge clk); tx_status = ST_IDLE;

      // R8 simultaneous rx and tx error
      do_push(2, 8'h60);
      expect_start("R8 start", 8'h60, 2);
      @(negedge clk); tx_status = ST_BUSY;
      @(negedge clk); tx_status = ST_ERR; rx_error = 1'b1; #1;
      check("R8 no clear", tx_clear, 0);
      @(negedge clk); tx_status = ST_IDLE; rx_error = 1'b0; #1;
      check("R8 reset_req", reset_req, 1);
      check("R10 flushed after R8", tx_start, 0);
      @(negedge clk); #1;
      check("R8 pulse ends", reset_req, 0);

      // R3 / R4 fill the ring
      tx_status = ST_BUSY;
      for (int p = 0; p < 7; p++) begin
         do_push(1, 8'(8'h80 + 8'(p)));
         if (p == 5) check("R3 not full at six", enq_full, 0);
      end
      check("R3 full at seven", enq_full, 1);
      do_push(1, 8'h99);
      check("R4 reset_req", reset_req, 1);
      check("R10 full cleared", enq_full, 0);
      tx_status = ST_IDLE;
      @(negedge clk); #1;
      check("R10 nothing pending", tx_start, 0);

      // R5 illegal lengths
      do_push(0, 8'h01);
      check("R5 zero length", tx_start, 0);
      do_push(17, 8'h02);
      check("R5 oversize length", tx_start, 0);
      check("R5 no full", enq_full, 0);

      // R9 busy watchdog exact trip
      @(negedge clk); tx_status = ST_BUSY;
      repeat (1999) @(negedge clk);
      #1; check("R9 not yet", reset_req, 0);
      @(negedge clk); #1;
      check("R9 trip at 2000", reset_req, 1);
      tx_status = ST_IDLE;
      @(negedge clk); tx_status = ST_BUSY;
      repeat (1000) @(negedge clk);
      tx_status = ST_IDLE;
      @(negedge clk); tx_status = ST_BUSY;
      seen = 0;
      repeat (1999) begin
         @(negedge clk); #1;
         if (reset_req) seen++;
      end
      check("R9 idle gap clears count", seen, 0);
      @(negedge clk); #1;
      check("R9 trip after gap", reset_req, 1);
      tx_status = ST_IDLE;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule